// File: doc/BRIEF.md
# Capture and Compare Timer Channel

This unit sits beside a free-running timer and one pin. It holds a single timer-wide capture/compare register and takes the timer count as an input. A four-bit mode code chooses what the channel does. In the capture modes it watches the pin for a chosen edge, with an optional divide-by-4 or divide-by-16 edge prescaler, and saves the timer count when a qualifying edge arrives. In the compare modes it watches for the timer count to equal the register and then drives the pin, raises an interrupt pulse, or asks the timer to restart and the converter to begin a conversion.

Captured counts leave through a valid/ready stream. `cap_valid` rises when a count is captured and stays high, with `cap_data` held, until a cycle in which `cap_ready` is also high. If a newer capture arrives before the older one is taken, the newer count replaces it. No capture is lost to back-pressure in any other way. The register itself is loaded through a plain write strobe, and every other pin is a plain level or a single-cycle pulse.

Top module: `ccm_unit`

## Requirements
- R1: Mode codes 0000, 0001, 0011 and 1100 to 1111 are idle. In an idle mode the unit raises no interrupt, timer-reset or conversion pulse, and it releases the pin (`pin_oe` low). Entering an idle mode drops any undelivered capture and clears the edge prescaler.
- R2: Mode 0101 captures on each rising edge of the pin and mode 0100 on each falling edge. The edge of the other polarity captures nothing. Each capture stores the timer count, presents it on the stream and gives one `irq_pulse`.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The edges in between produce no capture and no interrupt.
- R4: Any change of the mode code clears the edge prescale count, so the next capture needs a full set of edges.
- R5: While `cap_valid` is high and `cap_ready` is low, `cap_valid` stays high and `cap_data` stays unchanged, even if the register is written. The only exceptions are a newer capture, which replaces the data, and leaving the capture modes, which drops it.
- R6: Mode 0010 drives the pin and inverts it on each compare match.
- R7: Mode 1000 drives the pin low on entry and high on a match. Mode 1001 drives it high on entry and low on a match. Each match gives one `irq_pulse`.
- R8: Mode 1010 gives one `irq_pulse` per match. It leaves the pin released and raises no timer-reset or conversion request.
- R9: Mode 1011 answers each match with `timer_rst_req`, `adc_start_req` and `irq_pulse`, all high in the same single cycle.
- R10: A compare match acts once per arrival of the timer at the register value. However long the timer holds that value, it gives one action. A later arrival acts again.
- R11: `pin_oe` is high exactly in modes 0010, 1000 and 1001, from the cycle after the mode is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Channel mode code |
| timer_val | input | TW | Free-running timer count |
| ccr_wr_en | input | 1 | Load strobe for the capture/compare register |
| ccr_wr_data | input | TW | Value loaded by `ccr_wr_en` |
| pin_in | input | 1 | Asynchronous pin level for capture |
| pin_out | output | 1 | Pin drive level in compare modes |
| pin_oe | output | 1 | Pin drive enable |
| irq_pulse | output | 1 | One-cycle event flag |
| timer_rst_req | output | 1 | One-cycle timer restart request |
| adc_start_req | output | 1 | One-cycle conversion start request |
| cap_valid | output | 1 | Capture stream valid |
| cap_ready | input | 1 | Capture stream ready |
| cap_data | output | TW | Captured timer count |

## Verification
On every cycle, the assertions check the following. The idle modes stay silent. The special-event pulses appear together. Interrupt and prescale strobes never last two cycles. The prescale count stays within its divisor. A stalled capture keeps its valid flag and its data. Only the bench scenarios can show the rest: that the right edge polarity is chosen, that exactly every 4th or 16th edge is taken, and that a mode change restarts the prescaler. They also show the entry levels and match actions of each compare mode, and that a held timer value acts just once. A scoreboard matches each delivered capture against the count the bench expects.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  typedef enum logic [3:0] {
    MD_OFF        = 4'b0000,
    MD_RSV_A      = 4'b0001,
    MD_TOGGLE     = 4'b0010,
    MD_RSV_B      = 4'b0011,
    MD_CAP_FALL   = 4'b0100,
    MD_CAP_RISE   = 4'b0101,
    MD_CAP_RISE4  = 4'b0110,
    MD_CAP_RISE16 = 4'b0111,
    MD_CMP_SET    = 4'b1000,
    MD_CMP_CLR    = 4'b1001,
    MD_CMP_IRQ    = 4'b1010,
    MD_CMP_SPEC   = 4'b1011
  } ccm_mode_e;

  function automatic logic is_capture(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_compare(input logic [3:0] m);
    return (m == MD_TOGGLE) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic is_idle(input logic [3:0] m);
    return !is_capture(m) && !is_compare(m);
  endfunction

  function automatic logic drives_pin(input logic [3:0] m);
    return (m == MD_TOGGLE) || (m == MD_CMP_SET) || (m == MD_CMP_CLR);
  endfunction

  // log2 of the number of qualifying edges per capture
  function automatic logic [2:0] prescale_log2(input logic [3:0] m);
    case (m)
      MD_CAP_RISE4:  return 3'd2;
      MD_CAP_RISE16: return 3'd4;
      default:       return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ccm_edge_pre.sv
module ccm_edge_pre #(
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       cap_en,
  input  logic       clr,
  input  logic       sel_fall,
  input  logic [2:0] ps_log2,
  output logic       cap_stb
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [PS_W-1:0]        cnt_q;
  logic [PS_W-1:0]        lim;
  logic                   pin_s, rise, fall, edge_hit;

  // synchroniser chain, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign rise     = pin_s & ~prev_q;
  assign fall     = ~pin_s & prev_q;
  assign edge_hit = sel_fall ? fall : rise;

  always_comb lim = PS_W'((32'd1 << ps_log2) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      cap_stb <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      cap_stb <= 1'b0;
      if (!cap_en || clr) begin
        cnt_q <= '0;
      end else if (edge_hit) begin
        if (cnt_q >= lim) begin
          cnt_q   <= '0;
          cap_stb <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_PS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !clr) |-> (cnt_q <= lim)); // R3

  AST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb); // R3

  AST_CLR_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/ccm_cap_port.sv
module ccm_cap_port #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb,
  input  logic [TW-1:0] timer_val,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          ready,
  output logic          valid,
  output logic [TW-1:0] data,
  output logic [TW-1:0] ccr,
  output logic          irq_q
);

  logic take;
  assign take = en && stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      ccr   <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= take;
      if (take)       ccr <= timer_val;
      else if (wr_en) ccr <= wr_data;
      if (take) data <= timer_val;
      if (!en)                valid <= 1'b0;
      else if (take)          valid <= 1'b1;
      else if (valid && ready) valid <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && en) |=> valid); // R5

  AST_CAP_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !stb) |=> $stable(data)); // R5

  AST_CAP_IRQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R2

endmodule

// File: rtl/ccm_cmp.sv
module ccm_cmp
  import ccm_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          mode_chg,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] ccr,
  output logic          pin_q,
  output logic          irq_q,
  output logic          trst_q,
  output logic          adc_q
);

  logic active, match, hold_q, fire;

  assign active = is_compare(mode);
  assign match  = (timer_val == ccr);
  assign fire   = active && match && !hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pin_q  <= 1'b0;
      irq_q  <= 1'b0;
      trst_q <= 1'b0;
      adc_q  <= 1'b0;
    end else begin
      hold_q <= active && match;
      irq_q  <= fire;
      trst_q <= fire && (mode == MD_CMP_SPEC);
      adc_q  <= fire && (mode == MD_CMP_SPEC);
      if (mode_chg && mode == MD_CMP_SET) begin
        pin_q <= 1'b0;
      end else if (mode_chg && mode == MD_CMP_CLR) begin
        pin_q <= 1'b1;
      end else if (fire) begin
        case (mode)
          MD_CMP_SET: pin_q <= 1'b1;
          MD_CMP_CLR: pin_q <= 1'b0;
          MD_TOGGLE:  pin_q <= ~pin_q;
          default:    pin_q <= pin_q;
        endcase
      end else if (is_idle(mode)) begin
        pin_q <= 1'b0;
      end
    end
  end

  AST_SPECIAL_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (trst_q || adc_q) |-> (trst_q && adc_q && irq_q)); // R9

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R10

  AST_HELD_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && match && active && !mode_chg) |=> !irq_q); // R10

endmodule

// File: rtl/ccm_unit.sv
module ccm_unit
  import ccm_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic [TW-1:0] timer_val,
  input  logic          ccr_wr_en,
  input  logic [TW-1:0] ccr_wr_data,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq_pulse,
  output logic          timer_rst_req,
  output logic          adc_start_req,
  output logic          cap_valid,
  input  logic          cap_ready,
  output logic [TW-1:0] cap_data
);

  logic [3:0]    mode_q;
  logic          mode_chg;
  logic          cap_en;
  logic          cap_stb;
  logic [TW-1:0] ccr;
  logic          cap_irq, cmp_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MD_OFF;
    else        mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign cap_en   = is_capture(mode);

  ccm_edge_pre #(.SYNC_STAGES(SYNC_STAGES), .PS_W(PS_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .cap_en   (cap_en),
    .clr      (mode_chg),
    .sel_fall (mode == MD_CAP_FALL),
    .ps_log2  (prescale_log2(mode)),
    .cap_stb  (cap_stb)
  );

  ccm_cap_port #(.TW(TW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cap_en),
    .stb       (cap_stb),
    .timer_val (timer_val),
    .wr_en     (ccr_wr_en),
    .wr_data   (ccr_wr_data),
    .ready     (cap_ready),
    .valid     (cap_valid),
    .data      (cap_data),
    .ccr       (ccr),
    .irq_q     (cap_irq)
  );

  ccm_cmp #(.TW(TW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .timer_val (timer_val),
    .ccr       (ccr),
    .pin_q     (pin_out),
    .irq_q     (cmp_irq),
    .trst_q    (timer_rst_req),
    .adc_q     (adc_start_req)
  );

  assign irq_pulse = cap_irq | cmp_irq;
  assign pin_oe    = drives_pin(mode_q);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle(mode_q) |-> (!cap_valid && !irq_pulse && !timer_rst_req && !adc_start_req)); // R1

  AST_NO_DUAL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_irq && cmp_irq)); // R2

endmodule

// File: tb/ccm_unit_bench.sv
module ccm_unit_bench;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    mode = 4'd0;
  logic [TW-1:0] timer_val = '0;
  logic          ccr_wr_en = 1'b0;
  logic [TW-1:0] ccr_wr_data = '0;
  logic          pin_in = 1'b0;
  logic          pin_out, pin_oe, irq_pulse, timer_rst_req, adc_start_req;
  logic          cap_valid;
  logic          cap_ready = 1'b1;
  logic [TW-1:0] cap_data;

  int n_checks = 0;
  int n_errors = 0;
  int n_irq = 0, n_trst = 0, n_adc = 0, n_cap = 0;
  logic [TW-1:0] exp_q[$];

  always #10 clk = ~clk;

  ccm_unit u_ccm_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .timer_val(timer_val),
    .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pulse(irq_pulse),
    .timer_rst_req(timer_rst_req), .adc_start_req(adc_start_req),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_data(cap_data)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  // monitor: samples late in each cycle, just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (irq_pulse) n_irq++;
        if (timer_rst_req) n_trst++;
        if (adc_start_req) n_adc++;
        if (cap_valid && cap_ready) begin
          n_cap++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2/R3/R4 unexpected capture", int'(cap_data), 0);
          end else begin
            logic [TW-1:0] e;
            e = exp_q.pop_front();
            check(cap_data == e, "R2/R3 captured count", int'(cap_data), int'(e));
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    n_irq = 0; n_trst = 0; n_adc = 0; n_cap = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode = m;
    cyc(3);
  endtask

  task automatic drive_pin(input logic v, input logic [TW-1:0] t, input logic expect_cap);
    @(negedge clk);
    timer_val = t;
    pin_in = v;
    if (expect_cap) exp_q.push_back(t);
    cyc(8);
  endtask

  task automatic write_ccr(input logic [TW-1:0] v);
    @(negedge clk);
    ccr_wr_en = 1'b1;
    ccr_wr_data = v;
    @(negedge clk);
    ccr_wr_en = 1'b0;
  endtask

  task automatic set_timer(input logic [TW-1:0] t, input int hold);
    @(negedge clk);
    timer_val = t;
    cyc(hold);
  endtask

  initial begin
    logic p0;
    cyc(4);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1);
    // reset state
    check(!pin_oe && !irq_pulse && !cap_valid && !timer_rst_req && !adc_start_req,
          "R1 reset outputs", {pin_oe, irq_pulse, cap_valid, timer_rst_req}, 0);

    // R2 rising edge capture
    set_mode(4'b0101);
    clr_cnt();
    drive_pin(1'b1, 16'h1234, 1'b1);
    drive_pin(1'b0, 16'h5555, 1'b0);
    check(n_cap == 1, "R2 rising mode captures once", n_cap, 1);
    check(n_irq == 1, "R2 capture irq count", n_irq, 1);

    // R2 falling edge capture
    set_mode(4'b0100);
    clr_cnt();
    drive_pin(1'b1, 16'h0111, 1'b0);
    drive_pin(1'b0, 16'h0222, 1'b1);
    check(n_cap == 1, "R2 falling mode captures once", n_cap, 1);

    // R3 every 4th rising edge
    set_mode(4'b0110);
    clr_cnt();
    for (int i = 1; i <= 8; i++) begin
      drive_pin(1'b1, 16'(i), (i % 4) == 0);
      drive_pin(1'b0, 16'h00F0, 1'b0);
    end
    check(n_cap == 2, "R3 divide-by-4 captures", n_cap, 2);
    check(n_irq == 2, "R3 divide-by-4 irq", n_irq, 2);

    // R3 every 16th rising edge
    set_mode(4'b0111);
    clr_cnt();
    for (int i = 1; i <= 16; i++) begin
      drive_pin(1'b1, 16'(16'h0300 + i), i == 16);
      drive_pin(1'b0, 16'h00F0, 1'b0);
    end
    check(n_cap == 1, "R3 divide-by-16 captures", n_cap, 1);

    // R4 mode change clears prescale count
    set_mode(4'b0110);
    clr_cnt();
    for (int i = 0; i < 2; i++) begin
      drive_pin(1'b1, 16'h0400, 1'b0);
      drive_pin(1'b0, 16'h0400, 1'b0);
    end
    set_mode(4'b0111);
    set_mode(4'b0110);
    for (int i = 0; i < 2; i++) begin
      drive_pin(1'b1, 16'h0401, 1'b0);
      drive_pin(1'b0, 16'h0401, 1'b0);
    end
    check(n_cap == 0, "R4 no capture after cleared count", n_cap, 0);
    drive_pin(1'b1, 16'h0402, 1'b0);
    drive_pin(1'b0, 16'h0402, 1'b0);
    drive_pin(1'b1, 16'h0403, 1'b1);
    drive_pin(1'b0, 16'h0403, 1'b0);
    check(n_cap == 1, "R4 capture after full set", n_cap, 1);

    // R5 back-pressure
    set_mode(4'b0101);
    @(negedge clk);
    cap_ready = 1'b0;
    drive_pin(1'b1, 16'h0AAA, 1'b1);
    check(cap_valid && cap_data == 16'h0AAA, "R5 pending capture presented", int'(cap_data), 16'h0AAA);
    write_ccr(16'h7777);
    cyc(5);
    check(cap_valid && cap_data == 16'h0AAA, "R5 stalled data held", int'(cap_data), 16'h0AAA);
    drive_pin(1'b0, 16'h0AAA, 1'b0);
    void'(exp_q.pop_front());
    drive_pin(1'b1, 16'h0BBB, 1'b1);
    check(cap_valid && cap_data == 16'h0BBB, "R5 newer capture replaces", int'(cap_data), 16'h0BBB);
    clr_cnt();
    @(negedge clk);
    cap_ready = 1'b1;
    cyc(3);
    check(n_cap == 1 && !cap_valid, "R5 delivered once on ready", n_cap, 1);
    drive_pin(1'b0, 16'h0000, 1'b0);

    // R1 idle mode drops a pending capture
    @(negedge clk);
    cap_ready = 1'b0;
    drive_pin(1'b1, 16'h0CCC, 1'b0);
    set_mode(4'b0000);
    check(!cap_valid, "R1 idle drops capture", cap_valid, 0);
    @(negedge clk);
    cap_ready = 1'b1;
    drive_pin(1'b0, 16'h0000, 1'b0);

    // R7 set on match
    set_timer(16'd10, 1);
    write_ccr(16'd100);
    set_mode(4'b1000);
    check(pin_oe && !pin_out, "R7/R11 set mode entry low", {pin_oe, pin_out}, 2'b10);
    clr_cnt();
    set_timer(16'd99, 2);
    set_timer(16'd100, 6);
    check(pin_out == 1'b1, "R7 pin high on match", pin_out, 1);
    check(n_irq == 1, "R7/R10 one irq while held", n_irq, 1);

    // R7 clear on match
    set_timer(16'd50, 2);
    set_mode(4'b1001);
    check(pin_oe && pin_out, "R7 clear mode entry high", {pin_oe, pin_out}, 2'b11);
    clr_cnt();
    set_timer(16'd100, 6);
    check(pin_out == 1'b0 && n_irq == 1, "R7 pin low on match", {pin_out, 1'(n_irq)}, 2'b01);

    // R6 toggle
    set_timer(16'd50, 2);
    set_mode(4'b0010);
    check(pin_oe == 1'b1, "R11 toggle mode drives pin", pin_oe, 1);
    p0 = pin_out;
    clr_cnt();
    set_timer(16'd100, 6);
    check(pin_out == ~p0, "R6 toggle on match", pin_out, ~p0);
    set_timer(16'd50, 2);
    set_timer(16'd100, 6);
    check(pin_out == p0 && n_irq == 2, "R6/R10 second arrival toggles again", n_irq, 2);

    // R8 interrupt only
    set_timer(16'd50, 2);
    set_mode(4'b1010);
    check(pin_oe == 1'b0, "R8/R11 pin released", pin_oe, 0);
    clr_cnt();
    set_timer(16'd100, 6);
    check(n_irq == 1 && n_trst == 0 && n_adc == 0, "R8 irq only", n_irq * 16 + n_trst + n_adc, 16);

    // R9 special event
    set_timer(16'd50, 2);
    set_mode(4'b1011);
    clr_cnt();
    set_timer(16'd100, 6);
    check(n_trst == 1 && n_adc == 1 && n_irq == 1, "R9 special event pulses",
          n_irq * 256 + n_trst * 16 + n_adc, 16'h111);
    check(pin_oe == 1'b0, "R9/R11 pin released", pin_oe, 0);

    // R1 reserved modes stay quiet
    set_timer(16'd50, 2);
    set_mode(4'b0011);
    clr_cnt();
    set_timer(16'd100, 6);
    set_timer(16'd50, 2);
    set_mode(4'b0001);
    set_timer(16'd100, 6);
    check(n_irq == 0 && n_trst == 0 && pin_oe == 1'b0, "R1 reserved modes quiet", n_irq, 0);

    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule